// File: doc/BRIEF.md
# Baseband stall watchdog

This block guards a radio baseband against hangs. It watches the 4-bit current-state codes of seven internal sub-machines and the idle/non-idle mode flag. If none of them moves for longer than a programmed limit, it declares a hang. Time is counted on a coarse tick that a free prescaler makes from the input clock, one tick every 2^`TICK_LOG2` cycles. The limit for idle mode and the limit for non-idle mode are set on their own, and each mode has its own enable.

On expiry the block sets a sticky hang flag and stores a packed copy of all monitored states, so that software can later see where the baseband was stuck. It then raises a level interrupt and a reset request, each only if enabled. Software reaches the block through a small word-addressed register port with a one-cycle write strobe and a combinational read. Reading the status word with the read strobe restarts the timer. Writing zero to the hang bit rearms the block.

Top module: `bb_stall_wdog`

## Requirements
- R1: After reset the status word, control word 1 and control word 2 all read 0, and `wd_irq` and `wd_rst_req` are low.
- R2: Address 1 is control word 1 and address 2 is control word 2. Both are full 32-bit read/write storage. Address 3 reads 0, and writes to it change nothing.
- R3: In control word 1, bit 0 enables watching in non-idle mode and bit 1 enables it in idle mode. The non-idle limit sits in bits 15:2 and the idle limit in bits 31:16, both counted in ticks. After a restart with the mode enabled and limit L, the hang flag (status bit 3) is set exactly L·2^TICK_LOG2 + 1 clock edges later, counting from the restart edge, and not before. A mode whose enable bit is 0 never expires.
- R4: A limit of 0 for the current mode never expires.
- R5: Any change of `mon_state`, any change of `idle_mode`, or any write to control word 1 restarts both the prescaler and the timeout counter.
- R6: A status access at address 0 with `reg_re` high restarts the timer.
- R7: On expiry the status word becomes {mon_state[27:0], 1, info}. In `mon_state` the nibbles are, from bit 0 up: radar, receive OFDM, receive CCK, transmit OFDM, transmit CCK, gain control and search. The 3-bit info field is 3'b001 for an expiry in idle mode and 3'b010 for one in non-idle mode.
- R8: While the hang flag is set, the snapshot and info fields do not change, whatever the monitored states do.
- R9: A write to the status word with bit 3 = 0 clears the hang flag. A write with bit 3 = 1 leaves the whole status word unchanged.
- R10: `wd_irq` (enabled by control word 2 bit 2) and `wd_rst_req` (enabled by control word 2 bit 1) go high one clock after the hang flag and stay high while it is set. Both are low in the cycle after control word 1 has held both mode-enable bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | One-cycle write strobe |
| reg_re | input | 1 | Read strobe. At address 0 it restarts the timer |
| reg_addr | input | 2 | Word address: 0 status, 1 control 1, 2 control 2 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| mon_state | input | 28 | Seven packed 4-bit sub-machine states, radar in bits 3:0 |
| idle_mode | input | 1 | 1 = baseband idle, 0 = non-idle |
| wd_irq | output | 1 | Level interrupt on hang |
| wd_rst_req | output | 1 | Reset request on hang |

## Verification
The bench goes after the expiry edge itself. It checks that the flag is still clear one cycle before L ticks and set one cycle after, so a design that is off by one in the prescaler or the compare shows up at once. It moves the state inputs, toggles the mode and fires a status read partway through a count, where a design that forgot any one of these restart sources would expire early. After expiry it changes the monitored states and writes ones to the status word, which catches a snapshot that keeps following its inputs or a flag cleared by the wrong value. It also checks that a zero limit, a disabled mode and cleared enables keep the outputs quiet.

// File: rtl/bbw_pkg.sv
package bbw_pkg;
  localparam int NUM_MON  = 7;
  localparam int ST_W     = 4;
  localparam int MON_W    = NUM_MON * ST_W;
  localparam int DW       = 32;
  localparam int CNT_W    = 16;
  localparam int NI_LSB   = 2;
  localparam int ID_LSB   = 16;

  typedef enum logic [1:0] {
    ADR_STAT = 2'd0,
    ADR_CTL1 = 2'd1,
    ADR_CTL2 = 2'd2,
    ADR_NONE = 2'd3
  } bbw_addr_e;

  localparam int B_NI_EN   = 0;
  localparam int B_ID_EN   = 1;
  localparam int B_RST_EN  = 1;
  localparam int B_IRQ_EN  = 2;
  localparam int B_HANG    = 3;
endpackage

// File: rtl/bbw_timer.sv
module bbw_timer
  import bbw_pkg::*;
#(
  parameter int TICK_LOG2 = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MON_W-1:0] mon_state,
  input  logic             idle_mode,
  input  logic [DW-1:0]    ctl1,
  input  logic             ctl1_wr,
  input  logic             rd_restart,
  input  logic             hang,
  output logic             expire,
  output logic             en,
  output logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] tcnt
);
  localparam int NI_W = ID_LSB - NI_LSB;

  logic [MON_W-1:0]     mon_q;
  logic                 idle_q;
  logic [TICK_LOG2-1:0] pre;
  logic                 tick;
  logic                 activity;

  always_ff @(posedge clk) begin
    mon_q  <= mon_state;
    idle_q <= idle_mode;
  end

  assign activity = (mon_state != mon_q) || (idle_mode != idle_q) || rd_restart || ctl1_wr;
  assign en       = idle_mode ? ctl1[B_ID_EN] : ctl1[B_NI_EN];
  assign limit    = idle_mode ? ctl1[DW-1:ID_LSB]
                              : {{(CNT_W-NI_W){1'b0}}, ctl1[ID_LSB-1:NI_LSB]};
  assign tick     = &pre;
  assign expire   = en && (limit != '0) && (tcnt == limit) && !hang;

  always_ff @(posedge clk) begin
    if (rst || activity || !en || hang || expire) begin
      pre  <= '0;
      tcnt <= '0;
    end else begin
      pre <= pre + 1'b1;
      if (tick && !(&tcnt)) tcnt <= tcnt + 1'b1;
    end
  end
endmodule

// File: rtl/bbw_regs.sv
module bbw_regs
  import bbw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [MON_W-1:0] mon_state,
  input  logic             idle_mode,
  input  logic             expire,
  output logic [DW-1:0]    ctl1,
  output logic             irq_en,
  output logic             rst_en,
  output logic             ctl1_wr,
  output logic             rd_restart,
  output logic             hang,
  output logic [MON_W-1:0] snap
);
  logic [DW-1:0] ctl2;
  logic [2:0]    info;
  logic          stat_wr;

  assign ctl1_wr    = reg_we && (reg_addr == ADR_CTL1);
  assign stat_wr    = reg_we && (reg_addr == ADR_STAT);
  assign rd_restart = reg_re && (reg_addr == ADR_STAT);
  assign irq_en     = ctl2[B_IRQ_EN];
  assign rst_en     = ctl2[B_RST_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl1 <= '0;
      ctl2 <= '0;
      hang <= 1'b0;
      info <= '0;
    end else begin
      if (ctl1_wr) ctl1 <= reg_wdata;
      if (reg_we && (reg_addr == ADR_CTL2)) ctl2 <= reg_wdata;
      if (expire) begin
        hang <= 1'b1;
        info <= {1'b0, !idle_mode, idle_mode};
      end else if (stat_wr && !reg_wdata[B_HANG]) begin
        hang <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_MON; g++) begin : g_snap
    always_ff @(posedge clk) begin
      if (rst) snap[g*ST_W +: ST_W] <= '0;
      else if (expire) snap[g*ST_W +: ST_W] <= mon_state[g*ST_W +: ST_W];
    end
  end

  always_comb begin
    case (reg_addr)
      ADR_STAT: reg_rdata = {snap, hang, info};
      ADR_CTL1: reg_rdata = ctl1;
      ADR_CTL2: reg_rdata = ctl2;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bb_stall_wdog.sv
module bb_stall_wdog
  import bbw_pkg::*;
#(
  parameter int TICK_LOG2 = 15
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [27:0] mon_state,
  input  logic        idle_mode,
  output logic        wd_irq,
  output logic        wd_rst_req
);
  logic [DW-1:0]    ctl1;
  logic             irq_en, rst_en, ctl1_wr, rd_restart, hang, expire, en;
  logic [MON_W-1:0] snap;
  logic [CNT_W-1:0] limit, tcnt;
  logic             any_en;

  bbw_regs u_regs (
    .clk, .rst, .reg_we, .reg_re, .reg_addr, .reg_wdata, .reg_rdata,
    .mon_state, .idle_mode, .expire, .ctl1, .irq_en, .rst_en,
    .ctl1_wr, .rd_restart, .hang, .snap
  );

  bbw_timer #(.TICK_LOG2(TICK_LOG2)) u_timer (
    .clk, .rst, .mon_state, .idle_mode, .ctl1, .ctl1_wr, .rd_restart,
    .hang, .expire, .en, .limit, .tcnt
  );

  assign any_en = ctl1[B_NI_EN] | ctl1[B_ID_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_irq     <= 1'b0;
      wd_rst_req <= 1'b0;
    end else begin
      wd_irq     <= hang && irq_en && any_en;
      wd_rst_req <= hang && rst_en && any_en;
    end
  end
endmodule

// File: rtl/bbw_checker.sv
module bbw_checker (
  input logic        clk,
  input logic        rst,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [27:0] mon_state,
  input logic [31:0] ctl1,
  input logic        hang,
  input logic        en,
  input logic [15:0] limit,
  input logic [15:0] tcnt,
  input logic [27:0] snap,
  input logic        wd_irq,
  input logic        wd_rst_req
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (en && limit != 16'd0) |-> (tcnt <= limit));

  p_nonzero_limit_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(hang) |-> ($past(limit) != 16'd0));

  p_state_restart_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(mon_state) |=> (tcnt == 16'd0));

  p_snap_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (hang && $past(hang)) |-> $stable(snap));

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (hang && reg_we && reg_addr == 2'd0 && !reg_wdata[3]) |=> !hang);

  p_irq_follows_r10: assert property (@(posedge clk) disable iff (rst)
    (wd_irq || wd_rst_req) |-> $past(hang));

  p_quiet_off_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(ctl1[1:0]) == 2'b00) |-> (!wd_irq && !wd_rst_req));
endmodule

bind bb_stall_wdog bbw_checker u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mon_state(mon_state), .ctl1(ctl1), .hang(hang),
  .en(en), .limit(limit), .tcnt(tcnt), .snap(snap),
  .wd_irq(wd_irq), .wd_rst_req(wd_rst_req)
);

// File: tb/sim_bb_stall_wdog.sv
module sim_bb_stall_wdog;
  localparam int TL  = 4;
  localparam int TCK = 1 << TL;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [27:0] mon_state = '0;
  logic        idle_mode = 1'b0;
  logic        wd_irq, wd_rst_req;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bb_stall_wdog #(.TICK_LOG2(TL)) u0 (
    .clk, .rst, .reg_we, .reg_re, .reg_addr, .reg_wdata, .reg_rdata,
    .mon_state, .idle_mode, .wd_irq, .wd_rst_req
  );

  function automatic logic [31:0] exp_stat(input logic [27:0] m, input logic idl);
    return {m, 1'b1, 1'b0, !idl, idl};
  endfunction

  function automatic logic [31:0] ctl1_val(input logic idl, input int lim);
    if (idl) return {16'(lim), 14'd0, 2'b10};
    return {16'd0, 14'(lim), 2'b01};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_strobe();
    reg_re = 1'b1; reg_addr = 2'd0;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic chk_hang(input bit e, input string req);
    logic [31:0] v;
    peek(2'd0, v);
    chk(v[3] == e, req, {31'd0, v[3]}, {31'd0, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [27:0] m1;
    void'($urandom(32'd7321));
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    peek(2'd0, v); chk(v == 0, "R1 status", v, 0);
    peek(2'd1, v); chk(v == 0, "R1 ctl1", v, 0);
    peek(2'd2, v); chk(v == 0, "R1 ctl2", v, 0);
    chk(!wd_irq && !wd_rst_req, "R1 outputs", {30'd0, wd_irq, wd_rst_req}, 0);

    // R2 register storage
    wr(2'd2, 32'hA5A5_5A59); peek(2'd2, v); chk(v == 32'hA5A5_5A59, "R2 ctl2", v, 32'hA5A5_5A59);
    wr(2'd1, 32'h1234_0000); peek(2'd1, v); chk(v == 32'h1234_0000, "R2 ctl1", v, 32'h1234_0000);
    wr(2'd3, 32'hFFFF_FFFF); peek(2'd3, v); chk(v == 0, "R2 addr3", v, 0);
    peek(2'd1, v); chk(v == 32'h1234_0000, "R2 addr3 no effect", v, 32'h1234_0000);
    wr(2'd2, 32'h0000_0006);

    // R4 zero limit, R3 disabled mode
    mon_state = 28'h1111111; idle_mode = 1'b0; step(2);
    wr(2'd1, 32'h0000_0001); step(300); chk_hang(0, "R4 zero limit");
    wr(2'd1, ctl1_val(1'b1, 2)); step(200); chk_hang(0, "R3 disabled mode");

    // R3 exact expiry edge, R7 snapshot, R10 outputs
    wr(2'd1, ctl1_val(1'b0, 3));
    step(3*TCK); chk_hang(0, "R3 before limit");
    step(1); peek(2'd0, v); chk(v == exp_stat(28'h1111111, 1'b0), "R7 snapshot", v, exp_stat(28'h1111111, 1'b0));
    chk(!wd_irq, "R10 irq lag", {31'd0, wd_irq}, 0);
    step(1); chk(wd_irq && wd_rst_req, "R10 outputs high", {30'd0, wd_irq, wd_rst_req}, 3);

    // R8 frozen snapshot
    m1 = 28'h1111111;
    mon_state = 28'h9876543; step(5);
    peek(2'd0, v); chk(v == exp_stat(m1, 1'b0), "R8 frozen", v, exp_stat(m1, 1'b0));

    // R9 write with bit3=1 keeps status
    wr(2'd0, 32'hFFFF_FFFF);
    peek(2'd0, v); chk(v == exp_stat(m1, 1'b0), "R9 bit3 one keeps", v, exp_stat(m1, 1'b0));

    // R10 disabled enables silence outputs while hang stays
    wr(2'd1, 32'h0); step(1);
    chk(!wd_irq && !wd_rst_req, "R10 disabled quiet", {30'd0, wd_irq, wd_rst_req}, 0);
    chk_hang(1, "R10 hang kept");

    // R9 clear
    wr(2'd0, 32'h0); chk_hang(0, "R9 clear");

    // R5 state change mid-count
    wr(2'd1, ctl1_val(1'b0, 2)); step(20);
    mon_state = 28'h9876544;
    step(2*TCK+1); chk_hang(0, "R5 state restart");
    step(1); chk_hang(1, "R5 expiry after restart");
    wr(2'd0, 32'h0);

    // R5 mode toggle mid-count, both modes enabled with limit 2
    wr(2'd1, 32'h0002_000B); step(20);
    idle_mode = 1'b1;
    step(2*TCK+1); chk_hang(0, "R5 mode restart");
    step(1); peek(2'd0, v); chk(v == exp_stat(28'h9876544, 1'b1), "R5 R7 idle info", v, exp_stat(28'h9876544, 1'b1));
    wr(2'd0, 32'h0);

    // R6 status read restarts
    idle_mode = 1'b0; step(2);
    wr(2'd1, ctl1_val(1'b0, 2)); step(25);
    rd_strobe();
    step(2*TCK); chk_hang(0, "R6 read restart");
    step(1); chk_hang(1, "R6 expiry after read");
    wr(2'd0, 32'h0);

    // random scenarios
    for (int i = 0; i < 20; i++) begin
      logic idl;
      int lim;
      logic [27:0] m;
      logic [31:0] c2;
      idl = 1'($urandom % 2);
      lim = 1 + int'($urandom % 6);
      m   = 28'($urandom);
      c2  = $urandom;
      mon_state = m; idle_mode = idl; step(2);
      wr(2'd2, c2);
      wr(2'd1, ctl1_val(idl, lim));
      step(lim*TCK); chk_hang(0, "R3 random before");
      step(1); peek(2'd0, v); chk(v == exp_stat(m, idl), "R7 random snapshot", v, exp_stat(m, idl));
      step(1); chk({wd_irq, wd_rst_req} == {c2[2], c2[1]}, "R10 random outputs",
                   {30'd0, wd_irq, wd_rst_req}, {30'd0, c2[2], c2[1]});
      wr(2'd0, 32'h0); chk_hang(0, "R9 random clear");
      step(1); chk(!wd_irq && !wd_rst_req, "R10 random drop", {30'd0, wd_irq, wd_rst_req}, 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule